// File: doc/BRIEF.md
# Request-Synchronized DMA Channel Sequencer

This block sequences one logical DMA channel whose progress is paced by hardware request lines. It holds the channel's sync configuration, watches one selected line out of a bank, and decides how many elements each accepted request authorizes. A request may authorize one element, a whole frame, a whole block, or one packet. Each authorized element leaves the block as a valid/ready handshake on the element port. Address generation and data movement live elsewhere and consume that port.

After software enable the channel only arms itself. The channel context (remaining length, frame position) is loaded on the first accepted request of each block, never at enable. Completion of a packet, frame or block raises one-cycle event and interrupt pulses. The end of a block returns the channel to the armed state. Illegal sync/buffering/prefetch combinations are flagged and keep the channel from running. For destination-paced channels a prefetch port lets reads run ahead of any request, within a bounded window.

Back-pressure rules: `elem_valid` stays high and the grant does not advance while `elem_ready` is low. An element counts as granted only on a cycle where both are high. The same rules apply to `pf_valid`/`pf_ready`. Configuration inputs must be held stable while `sw_enable` is high.

Top module: `dma_sync_seq`

## Requirements
- R1: The request select is the 7-bit value {req_sel_hi, req_sel_lo}. A value N in 1..REQ_LINES makes only `req_lines[N-1]` able to activate the channel; all other lines have no effect.
- R2: From `sw_enable` rising, the channel is armed but inactive (`active`=0, no `elem_valid`, no `ctx_load`) until the selected line is seen high. `ctx_load` then pulses for exactly one cycle, once per block, as `active` rises.
- R3: The pair {sync_block, sync_frame} selects the amount per request: 00 = one element, 01 = the rest of the current frame, 10 = the rest of the block, 11 = one packet.
- R4: The packet size is `dst_index` when `sync_on_src`=1 and `src_index` when `sync_on_src`=0. A size of 0 is treated as 1.
- R5: When the remaining block length is smaller than the packet size, the last packet grants only the remaining elements.
- R6: A block is `elem_cnt`×`frame_cnt` elements. `eof`/`irq_frame` pulse the cycle after the last element of each frame is granted. `eob`/`irq_block` pulse the cycle after the last element of the block is granted; `active` is low in that cycle. The next accepted request reloads the context.
- R7: `eop` pulses the cycle after each packet's last grant. `irq_pkt` pulses with it only when `sync_on_src`=0; a source-synchronized channel never raises `irq_pkt`.
- R8: `cfg_err` is high when buffering is disabled on a destination-synchronized channel, when prefetch is enabled on a source-synchronized channel, or when `elem_cnt` or `frame_cnt` is zero. While it is high, no context is loaded and no element is granted.
- R9: When `prefetch_en`=1 and `sync_on_src`=0, the armed or active channel offers `pf_valid` handshakes before any request. The number of prefetch handshakes per block is limited to the smaller of the block length and FIFO_DEPTH.
- R10: A select value of 0 means software-triggered: the channel behaves as if its request line were always high.
- R11: `elem_valid` holds while `elem_ready` is low. The line is sampled as a level, and a new request is accepted only after the grant of the previous one has completed.
- R12: Dropping `sw_enable` aborts the channel: `elem_valid` and `active` are low one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_enable | input | 1 | Software channel enable |
| req_sel_lo | input | 5 | Low part of the 1-based request select |
| req_sel_hi | input | 2 | High part of the 1-based request select |
| sync_frame | input | 1 | Frame sync bit |
| sync_block | input | 1 | Block sync bit |
| sync_on_src | input | 1 | 1 = source-synchronized, 0 = destination-synchronized |
| prefetch_en | input | 1 | Prefetch enable |
| buf_disable | input | 1 | Buffering disable |
| elem_cnt | input | CNT_W | Elements per frame |
| frame_cnt | input | CNT_W | Frames per block |
| src_index | input | CNT_W | Source-side index value (packet size when destination-synchronized) |
| dst_index | input | CNT_W | Destination-side index value (packet size when source-synchronized) |
| req_lines | input | REQ_LINES | DMA request line bank, level-sensitive |
| elem_valid | output | 1 | An authorized element is offered |
| elem_ready | input | 1 | Downstream accepts the element |
| pf_valid | output | 1 | A prefetch read may be issued |
| pf_ready | input | 1 | Prefetch read accepted |
| ctx_load | output | 1 | One-cycle context-load strobe |
| active | output | 1 | Channel is active (granting or waiting between requests) |
| cfg_err | output | 1 | Illegal configuration |
| eop | output | 1 | End-of-packet event pulse |
| eof | output | 1 | End-of-frame event pulse |
| eob | output | 1 | End-of-block event pulse |
| irq_pkt | output | 1 | Packet interrupt pulse |
| irq_frame | output | 1 | Frame interrupt pulse |
| irq_block | output | 1 | Block interrupt pulse |

## Verification
The grant engine is driven with each of the four sync encodings on blocks of different shapes. Element mode shows one grant per request. Frame mode shows per-frame counts and frame events. Block mode shows that one request drains everything. Packet mode uses the two index values set to different sizes, so a grant count reveals which one was taken. Packet runs use a block that is not a multiple of the packet size, which exposes the short final packet, and are repeated in both sync directions to separate the packet-interrupt suppression. Requests on a neighbouring line and on the highest line check the select decode. A stalled `elem_ready`, a mid-block disable, a zero select and the prefetch window with a block smaller and larger than the FIFO depth cover the remaining paths.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  // {block_bit, frame_bit}
  typedef enum logic [1:0] {
    MODE_ELEM  = 2'b00,
    MODE_FRAME = 2'b01,
    MODE_BLOCK = 2'b10,
    MODE_PKT   = 2'b11
  } sync_mode_e;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ARMED = 2'd1,
    ST_GRANT = 2'd2,
    ST_WAIT  = 2'd3
  } ch_state_e;

  localparam int SEL_LO_W = 5;
  localparam int SEL_HI_W = 2;
  localparam int SEL_W    = SEL_LO_W + SEL_HI_W;

endpackage

// File: rtl/dma_req_select.sv
module dma_req_select
  import dma_seq_pkg::*;
#(
  parameter int REQ_LINES = 127
) (
  input  logic [SEL_W-1:0]     sel,
  input  logic [REQ_LINES-1:0] req_lines,
  output logic                 hit
);

  logic [REQ_LINES-1:0] match;

  for (genvar i = 0; i < REQ_LINES; i++) begin : g_line
    assign match[i] = req_lines[i] && (sel == SEL_W'(i + 1));
  end

  // select 0: software-triggered, request always present
  assign hit = (sel == '0) ? 1'b1 : |match;

endmodule

// File: rtl/dma_cfg_check.sv
module dma_cfg_check #(
  parameter int CNT_W = 16
) (
  input  logic             sync_on_src,
  input  logic             prefetch_en,
  input  logic             buf_disable,
  input  logic [CNT_W-1:0] elem_cnt,
  input  logic [CNT_W-1:0] frame_cnt,
  output logic             cfg_err
);

  logic bad_buf, bad_pf, bad_len;

  assign bad_buf = buf_disable && !sync_on_src;
  assign bad_pf  = prefetch_en && sync_on_src;
  assign bad_len = (elem_cnt == '0) || (frame_cnt == '0);
  assign cfg_err = bad_buf || bad_pf || bad_len;

endmodule

// File: rtl/dma_xfer_count.sv
module dma_xfer_count
  import dma_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int TOT_W = 2 * CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             start,
  input  logic             step,
  input  sync_mode_e       mode,
  input  logic [TOT_W-1:0] total,
  input  logic [CNT_W-1:0] elem_cnt,
  input  logic [CNT_W-1:0] pkt_size,
  output logic             last_req,
  output logic             last_frame,
  output logic             last_block
);

  logic [TOT_W-1:0] remaining;
  logic [CNT_W-1:0] frame_left;
  logic [TOT_W-1:0] quota;

  function automatic logic [TOT_W-1:0] quota_of(
    input sync_mode_e       m,
    input logic [TOT_W-1:0] rem,
    input logic [CNT_W-1:0] fl,
    input logic [CNT_W-1:0] pk
  );
    logic [TOT_W-1:0] p;
    p = (pk == '0) ? TOT_W'(1) : {{CNT_W{1'b0}}, pk};
    case (m)
      MODE_ELEM:  return TOT_W'(1);
      MODE_FRAME: return {{CNT_W{1'b0}}, fl};
      MODE_BLOCK: return rem;
      default:    return (p < rem) ? p : rem;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining  <= '0;
      frame_left <= '0;
      quota      <= '0;
    end else if (load) begin
      remaining  <= total;
      frame_left <= elem_cnt;
      quota      <= quota_of(mode, total, elem_cnt, pkt_size);
    end else if (start) begin
      quota      <= quota_of(mode, remaining, frame_left, pkt_size);
    end else if (step) begin
      remaining  <= remaining - TOT_W'(1);
      frame_left <= (frame_left == CNT_W'(1)) ? elem_cnt : frame_left - CNT_W'(1);
      quota      <= quota - TOT_W'(1);
    end
  end

  assign last_req   = (quota == TOT_W'(1));
  assign last_frame = (frame_left == CNT_W'(1));
  assign last_block = (remaining == TOT_W'(1));

endmodule

// File: rtl/dma_prefetch_ctl.sv
module dma_prefetch_ctl #(
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 8,
  localparam int TOT_W = 2 * CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [TOT_W-1:0] total,
  input  logic             pf_ready,
  output logic             pf_valid
);

  localparam logic [TOT_W-1:0] DEPTH = TOT_W'(FIFO_DEPTH);

  logic [TOT_W-1:0] issued;
  logic [TOT_W-1:0] limit;

  assign limit    = (total < DEPTH) ? total : DEPTH;
  assign pf_valid = run && (issued < limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                issued <= '0;
    else if (!run || clear)    issued <= '0;
    else if (pf_valid && pf_ready) issued <= issued + TOT_W'(1);
  end

endmodule

// File: rtl/dma_sync_seq.sv
module dma_sync_seq
  import dma_seq_pkg::*;
#(
  parameter int REQ_LINES  = 127,
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sw_enable,
  input  logic [4:0]           req_sel_lo,
  input  logic [1:0]           req_sel_hi,
  input  logic                 sync_frame,
  input  logic                 sync_block,
  input  logic                 sync_on_src,
  input  logic                 prefetch_en,
  input  logic                 buf_disable,
  input  logic [CNT_W-1:0]     elem_cnt,
  input  logic [CNT_W-1:0]     frame_cnt,
  input  logic [CNT_W-1:0]     src_index,
  input  logic [CNT_W-1:0]     dst_index,
  input  logic [REQ_LINES-1:0] req_lines,
  output logic                 elem_valid,
  input  logic                 elem_ready,
  output logic                 pf_valid,
  input  logic                 pf_ready,
  output logic                 ctx_load,
  output logic                 active,
  output logic                 cfg_err,
  output logic                 eop,
  output logic                 eof,
  output logic                 eob,
  output logic                 irq_pkt,
  output logic                 irq_frame,
  output logic                 irq_block
);

  localparam int TOT_W = 2 * CNT_W;

  ch_state_e        st;
  sync_mode_e       mode;
  logic             hit, go, step, load, start;
  logic             last_req, last_frame, last_block;
  logic [TOT_W-1:0] total;
  logic [CNT_W-1:0] pkt_size;
  logic             pkt_mode, block_done;

  assign mode     = sync_mode_e'({sync_block, sync_frame});
  assign pkt_mode = (mode == MODE_PKT);
  assign pkt_size = sync_on_src ? dst_index : src_index;
  assign total    = TOT_W'(elem_cnt) * TOT_W'(frame_cnt);

  dma_req_select #(.REQ_LINES(REQ_LINES)) i_sel (
    .sel       ({req_sel_hi, req_sel_lo}),
    .req_lines (req_lines),
    .hit       (hit)
  );

  dma_cfg_check #(.CNT_W(CNT_W)) i_chk_cfg (
    .sync_on_src (sync_on_src),
    .prefetch_en (prefetch_en),
    .buf_disable (buf_disable),
    .elem_cnt    (elem_cnt),
    .frame_cnt   (frame_cnt),
    .cfg_err     (cfg_err)
  );

  assign go         = sw_enable && !cfg_err;
  assign elem_valid = (st == ST_GRANT);
  assign active     = (st == ST_GRANT) || (st == ST_WAIT);
  assign step       = elem_valid && elem_ready;
  assign load       = go && (st == ST_ARMED) && hit;
  assign start      = go && (st == ST_WAIT) && hit;
  assign block_done = step && last_block;

  dma_xfer_count #(.CNT_W(CNT_W)) i_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .start      (start),
    .step       (step),
    .mode       (mode),
    .total      (total),
    .elem_cnt   (elem_cnt),
    .pkt_size   (pkt_size),
    .last_req   (last_req),
    .last_frame (last_frame),
    .last_block (last_block)
  );

  dma_prefetch_ctl #(.CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH)) i_pf (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (go && prefetch_en && !sync_on_src && (st != ST_OFF)),
    .clear    (block_done),
    .total    (total),
    .pf_ready (pf_ready),
    .pf_valid (pf_valid)
  );

  // channel state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_OFF;
      ctx_load <= 1'b0;
    end else begin
      ctx_load <= 1'b0;
      if (!go) begin
        st <= ST_OFF;
      end else begin
        case (st)
          ST_OFF:   st <= ST_ARMED;
          ST_ARMED: if (hit) begin
                      st       <= ST_GRANT;
                      ctx_load <= 1'b1;
                    end
          ST_GRANT: if (step && last_req) st <= last_block ? ST_ARMED : ST_WAIT;
          ST_WAIT:  if (hit) st <= ST_GRANT;
          default:  st <= ST_OFF;
        endcase
      end
    end
  end

  // completion events and interrupts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eop       <= 1'b0;
      eof       <= 1'b0;
      eob       <= 1'b0;
      irq_pkt   <= 1'b0;
      irq_frame <= 1'b0;
      irq_block <= 1'b0;
    end else begin
      eop       <= step && pkt_mode && last_req;
      eof       <= step && last_frame;
      eob       <= step && last_block;
      irq_pkt   <= step && pkt_mode && last_req && !sync_on_src;
      irq_frame <= step && last_frame;
      irq_block <= step && last_block;
    end
  end

endmodule

// File: rtl/dma_sync_seq_chk.sv
module dma_sync_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic sw_enable,
  input logic sync_on_src,
  input logic prefetch_en,
  input logic elem_valid,
  input logic elem_ready,
  input logic pf_valid,
  input logic ctx_load,
  input logic active,
  input logic cfg_err,
  input logic eob,
  input logic irq_pkt
);

  // R11: offered element is held under back-pressure
  p_hold_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_valid && !elem_ready && sw_enable && !cfg_err) |=> elem_valid);

  // R2: context load is a single-cycle strobe
  p_ctx_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_load |=> !ctx_load);

  // R2: context load coincides with activation
  p_ctx_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_load |-> active);

  // R2: no grant while inactive
  p_idle_no_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !elem_valid);

  // R8: a standing configuration error keeps the channel inactive
  p_err_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && $past(cfg_err)) |-> !active);

  // R6: block end leaves the channel inactive
  p_eob_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eob |-> !active);

  // R7: no packet interrupt for source-synchronized channels
  p_src_no_pkt_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pkt |-> !sync_on_src);

  // R9: prefetch only for destination-synchronized prefetch channels
  p_pf_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (prefetch_en && !sync_on_src));

  // R12: disable drops the grant within one cycle
  p_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_enable |=> !elem_valid);

endmodule

bind dma_sync_seq dma_sync_seq_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sw_enable   (sw_enable),
  .sync_on_src (sync_on_src),
  .prefetch_en (prefetch_en),
  .elem_valid  (elem_valid),
  .elem_ready  (elem_ready),
  .pf_valid    (pf_valid),
  .ctx_load    (ctx_load),
  .active      (active),
  .cfg_err     (cfg_err),
  .eob         (eob),
  .irq_pkt     (irq_pkt)
);

// File: tb/test_dma_sync_seq.sv
`timescale 1ns/1ps
module test_dma_sync_seq;

  localparam int LINES = 127;
  localparam int CW    = 16;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_enable = 1'b0;
  logic [4:0] req_sel_lo = '0;
  logic [1:0] req_sel_hi = '0;
  logic sync_frame = 1'b0, sync_block = 1'b0, sync_on_src = 1'b0;
  logic prefetch_en = 1'b0, buf_disable = 1'b0;
  logic [CW-1:0] elem_cnt = 1, frame_cnt = 1, src_index = 0, dst_index = 0;
  logic [LINES-1:0] req_lines = '0;
  logic elem_valid, elem_ready = 1'b1, pf_valid, pf_ready = 1'b1;
  logic ctx_load, active, cfg_err, eop, eof, eob, irq_pkt, irq_frame, irq_block;

  int checks = 0, errors = 0;
  int hs = 0, pf = 0, ctx = 0, n_eop = 0, n_eof = 0, n_eob = 0, n_ipk = 0, n_ifr = 0, n_ibl = 0;

  always #2.5 clk = ~clk;

  dma_sync_seq #(.REQ_LINES(LINES), .CNT_W(CW), .FIFO_DEPTH(DEPTH)) i_dma_sync_seq (
    .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable),
    .req_sel_lo(req_sel_lo), .req_sel_hi(req_sel_hi),
    .sync_frame(sync_frame), .sync_block(sync_block), .sync_on_src(sync_on_src),
    .prefetch_en(prefetch_en), .buf_disable(buf_disable),
    .elem_cnt(elem_cnt), .frame_cnt(frame_cnt), .src_index(src_index), .dst_index(dst_index),
    .req_lines(req_lines), .elem_valid(elem_valid), .elem_ready(elem_ready),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .ctx_load(ctx_load), .active(active),
    .cfg_err(cfg_err), .eop(eop), .eof(eof), .eob(eob),
    .irq_pkt(irq_pkt), .irq_frame(irq_frame), .irq_block(irq_block)
  );

  // monitor, away from the active edge
  always @(negedge clk) begin
    if (elem_valid && elem_ready) hs++;
    if (pf_valid && pf_ready) pf++;
    if (ctx_load) ctx++;
    if (eop) n_eop++;
    if (eof) n_eof++;
    if (eob) n_eob++;
    if (irq_pkt) n_ipk++;
    if (irq_frame) n_ifr++;
    if (irq_block) n_ibl++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic set_cfg(input int sel, input bit fs, input bit bs, input bit src,
                         input bit pfe, input bit bd, input int ec, input int fc,
                         input int si, input int di);
    @(posedge clk); #1;
    sw_enable   = 1'b0;
    req_sel_lo  = 5'(sel);
    req_sel_hi  = 2'(sel >> 5);
    sync_frame  = fs;
    sync_block  = bs;
    sync_on_src = src;
    prefetch_en = pfe;
    buf_disable = bd;
    elem_cnt    = CW'(ec);
    frame_cnt   = CW'(fc);
    src_index   = CW'(si);
    dst_index   = CW'(di);
    settle(2);
  endtask

  task automatic enable_ch();
    @(posedge clk); #1;
    sw_enable = 1'b1;
    settle(3);
  endtask

  // raise a line until the grant starts, drop it, wait for the grant to end
  task automatic fire(input int line);
    int g;
    @(posedge clk); #1;
    req_lines[line] = 1'b1;
    g = 0;
    do begin @(negedge clk); g++; end while (!elem_valid && g < 40);
    req_lines[line] = 1'b0;
    g = 0;
    while (elem_valid && g < 2000) begin @(negedge clk); g++; end
    settle(3);
  endtask

  task automatic t_reset();
    chk_eq("R2 reset active", int'(active), 0);
    chk_eq("R2 reset elem_valid", int'(elem_valid), 0);
    chk_eq("R2 reset ctx_load", int'(ctx_load), 0);
    chk_eq("R9 reset pf_valid", int'(pf_valid), 0);
  endtask

  // R1/R2: arm without activation, wrong line ignored, right line activates
  task automatic t_select_arm();
    int h0, c0;
    set_cfg(5, 0, 0, 0, 0, 0, 3, 2, 0, 0);
    h0 = hs; c0 = ctx;
    enable_ch();
    settle(8);
    chk_eq("R2 armed not active", int'(active), 0);
    chk_eq("R2 no ctx before request", ctx - c0, 0);
    @(posedge clk); #1; req_lines[5] = 1'b1; req_lines[3] = 1'b1;
    settle(8);
    req_lines = '0;
    chk_eq("R1 other lines ignored grants", hs - h0, 0);
    chk_eq("R1 other lines ignored ctx", ctx - c0, 0);
    fire(4);
    chk_eq("R3 element mode one grant", hs - h0, 1);
    chk_eq("R2 ctx on first request", ctx - c0, 1);
    fire(4);
    chk_eq("R2 ctx only once per block", ctx - c0, 1);
    chk_eq("R3 element mode second grant", hs - h0, 2);
    // highest select uses upper field
    set_cfg(127, 0, 0, 0, 0, 0, 2, 1, 0, 0);
    h0 = hs;
    enable_ch();
    fire(126);
    chk_eq("R1 upper field selects line 126", hs - h0, 1);
  endtask

  // R3/R6: frame mode and block rollover
  task automatic t_frame();
    int h0, f0, b0, ib0, if0, c0;
    set_cfg(11, 1, 0, 0, 0, 0, 4, 3, 0, 0);
    enable_ch();
    h0 = hs; f0 = n_eof; b0 = n_eob; ib0 = n_ibl; if0 = n_ifr; c0 = ctx;
    fire(10);
    chk_eq("R3 frame mode grants", hs - h0, 4);
    chk_eq("R6 eof per frame", n_eof - f0, 1);
    fire(10);
    fire(10);
    chk_eq("R6 block length 12", hs - h0, 12);
    chk_eq("R6 eof count", n_eof - f0, 3);
    chk_eq("R6 irq_frame count", n_ifr - if0, 3);
    chk_eq("R6 eob once", n_eob - b0, 1);
    chk_eq("R6 irq_block once", n_ibl - ib0, 1);
    chk_eq("R6 inactive after block", int'(active), 0);
    fire(10);
    chk_eq("R6 context reload next block", ctx - c0, 2);
    chk_eq("R6 new block frame grants", hs - h0, 16);
  endtask

  task automatic t_block();
    int h0, f0, b0;
    set_cfg(2, 0, 1, 0, 0, 0, 3, 2, 0, 0);
    enable_ch();
    h0 = hs; f0 = n_eof; b0 = n_eob;
    fire(1);
    chk_eq("R3 block mode grants", hs - h0, 6);
    chk_eq("R6 block mode eof", n_eof - f0, 2);
    chk_eq("R6 block mode eob", n_eob - b0, 1);
  endtask

  // R4/R5/R7 destination-synchronized packets: size from src_index
  task automatic t_pkt_dst();
    int h0, p0, i0, h1;
    set_cfg(8, 1, 1, 0, 0, 0, 5, 2, 4, 7);
    enable_ch();
    h0 = hs; p0 = n_eop; i0 = n_ipk;
    fire(7);
    chk_eq("R4 dst-sync packet uses src_index", hs - h0, 4);
    fire(7);
    h1 = hs;
    fire(7);
    chk_eq("R5 short final packet", hs - h1, 2);
    chk_eq("R7 eop per packet", n_eop - p0, 3);
    chk_eq("R7 irq_pkt dst-sync", n_ipk - i0, 3);
  endtask

  task automatic t_pkt_src();
    int h0, p0, i0, h1;
    set_cfg(9, 1, 1, 1, 0, 1, 5, 2, 9, 3);
    enable_ch();
    chk_eq("R8 src-sync buffering off legal", int'(cfg_err), 0);
    h0 = hs; p0 = n_eop; i0 = n_ipk;
    fire(8);
    chk_eq("R4 src-sync packet uses dst_index", hs - h0, 3);
    fire(8);
    fire(8);
    h1 = hs;
    fire(8);
    chk_eq("R5 remainder packet src-sync", hs - h1, 1);
    chk_eq("R7 eop src-sync", n_eop - p0, 4);
    chk_eq("R7 no irq_pkt src-sync", n_ipk - i0, 0);
  endtask

  task automatic t_cfg_err();
    int h0, c0;
    set_cfg(3, 0, 0, 0, 0, 1, 2, 2, 0, 0);
    chk_eq("R8 dst-sync buffering off flagged", int'(cfg_err), 1);
    h0 = hs; c0 = ctx;
    enable_ch();
    @(posedge clk); #1; req_lines[2] = 1'b1;
    settle(10);
    req_lines = '0;
    chk_eq("R8 no grant on error", hs - h0, 0);
    chk_eq("R8 no ctx on error", ctx - c0, 0);
    set_cfg(3, 0, 0, 1, 1, 0, 2, 2, 0, 0);
    chk_eq("R8 src-sync prefetch flagged", int'(cfg_err), 1);
    set_cfg(3, 0, 0, 0, 0, 0, 0, 2, 0, 0);
    chk_eq("R8 zero length flagged", int'(cfg_err), 1);
    set_cfg(3, 0, 0, 0, 0, 0, 2, 2, 0, 0);
    chk_eq("R8 legal config clear", int'(cfg_err), 0);
  endtask

  task automatic t_sw_trigger();
    int h0, g;
    set_cfg(0, 0, 0, 0, 0, 0, 2, 2, 0, 0);
    h0 = hs;
    @(posedge clk); #1; sw_enable = 1'b1;
    g = 0;
    do begin @(negedge clk); g++; end while (!eob && g < 100);
    sw_enable = 1'b0;
    settle(3);
    chk_eq("R10 software trigger runs block", hs - h0, 4);
    chk_eq("R12 disabled after stop", int'(active), 0);
  endtask

  task automatic t_prefetch();
    int p0;
    set_cfg(4, 0, 0, 0, 1, 0, 4, 4, 0, 0);
    p0 = pf;
    enable_ch();
    settle(30);
    chk_eq("R9 prefetch capped by depth", pf - p0, DEPTH);
    chk_eq("R9 prefetch stopped", int'(pf_valid), 0);
    chk_eq("R9 prefetch without activation", int'(active), 0);
    set_cfg(4, 0, 0, 0, 1, 0, 5, 1, 0, 0);
    p0 = pf;
    enable_ch();
    settle(30);
    chk_eq("R9 prefetch capped by block", pf - p0, 5);
  endtask

  task automatic t_backpressure();
    int h0, g;
    set_cfg(6, 1, 0, 0, 0, 0, 4, 1, 0, 0);
    enable_ch();
    h0 = hs;
    @(posedge clk); #1; elem_ready = 1'b0; req_lines[5] = 1'b1;
    g = 0;
    do begin @(negedge clk); g++; end while (!elem_valid && g < 40);
    req_lines[5] = 1'b0;
    settle(5);
    chk_eq("R11 valid held while stalled", int'(elem_valid), 1);
    chk_eq("R11 no grant while stalled", hs - h0, 0);
    @(posedge clk); #1; elem_ready = 1'b1;
    @(posedge clk); #1; elem_ready = 1'b0;
    settle(3);
    chk_eq("R11 one grant per handshake", hs - h0, 1);
    @(posedge clk); #1; elem_ready = 1'b1;
    settle(10);
    chk_eq("R11 frame completes after stall", hs - h0, 4);
  endtask

  task automatic t_abort();
    int h0;
    set_cfg(12, 0, 1, 0, 0, 0, 8, 8, 0, 0);
    enable_ch();
    h0 = hs;
    @(posedge clk); #1; req_lines[11] = 1'b1;
    settle(8);
    req_lines[11] = 1'b0;
    @(posedge clk); #1; sw_enable = 1'b0;
    settle(2);
    chk_eq("R12 grant stops on disable", int'(elem_valid), 0);
    chk_eq("R12 inactive on disable", int'(active), 0);
    chk(hs - h0 < 64 && hs - h0 > 0, "R12 partial block", hs - h0, 64);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    report();
    $finish;
  end

  initial begin
    settle(3);
    @(posedge clk); #1; rst_n = 1'b1;
    settle(2);
    t_reset();
    t_select_arm();
    t_frame();
    t_block();
    t_pkt_dst();
    t_pkt_src();
    t_cfg_err();
    t_sw_trigger();
    t_prefetch();
    t_backpressure();
    t_abort();
    report();
    $finish;
  end

endmodule